// File: doc/BRIEF.md
# Bitplane Video Enable and Group Select

This block sits between a sixteen-plane bitmap pixel stream and the eight-bit index input of a color lookup table. Every pixel clock it accepts one pixel word that carries one bit per bitmap plane. It clears the bits of planes that are switched off, then hands one group of eight planes to the lookup table as its index. Clearing a plane's enable has the same effect as removing that plane: fewer colors can be reached.

The plane enables are held in a sixteen-bit register. A CPU-style port reads and writes this register, and the port accepts only whole-word accesses. A separate image-select input picks which half of the planes is shown. The result is registered, and a valid flag travels with it.

Top module: `bitplane_index_gate`

## Requirements
- R1: After reset the plane-enable register holds 16'hFFFF, so every plane is visible. `lut_valid`, `lut_idx`, `reg_rdata` and `reg_acc_err` are all zero.
- R2: A write with `reg_be == 2'b11` loads `reg_wdata` into the enable register. A read with `reg_be == 2'b11` returns the register value on `reg_rdata` one cycle later. In cycles with no such read, `reg_rdata` is zero.
- R3: A write with `reg_be` other than 2'b11 leaves the enable register unchanged.
- R4: A read with `reg_be` other than 2'b11 returns zero on `reg_rdata` in the following cycle.
- R5: A read or write with `reg_be` other than 2'b11 raises `reg_acc_err` for exactly the following cycle. Whole-word accesses never raise it.
- R6: Bit p of the pixel word reaches the index only while enable bit p is 1. Otherwise that bit is forced to 0.
- R7: With `img_sel == 0`, `lut_idx` carries masked planes 7..0, with plane 0 in bit 0.
- R8: With `img_sel == 1`, `lut_idx` carries masked planes 15..8, with plane 8 in bit 0.
- R9: `lut_valid` equals `pix_valid` delayed by one clock, and `lut_idx` shows the result for that pixel in the same cycle. `lut_idx` holds its value while `pix_valid` is 0.
- R10: A pixel presented in the same cycle as an enable write is masked with the old enable value. The next pixel uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_be | input | 2 | Byte-lane enables; only 2'b11 is a legal access |
| reg_wdata | input | 16 | Write data for the enable register |
| reg_rdata | output | 16 | Read data, one cycle after the read |
| reg_acc_err | output | 1 | One-cycle pulse after an access that is not a whole word |
| pix_valid | input | 1 | Pixel word present this cycle |
| pix_word | input | 16 | One bit per bitmap plane |
| img_sel | input | 1 | Group select: 0 picks planes 7..0, 1 picks planes 15..8 |
| lut_valid | output | 1 | Index valid, one cycle after `pix_valid` |
| lut_idx | output | 8 | Lookup table index |

## Verification
The bench builds the block with its default parameters: sixteen planes in two groups of eight and a two-byte register port. With these values both select settings and every byte-enable pattern can be reached. Every plane bit can be exercised against its own enable bit. The bench models the register and the pipeline behaviourally and compares all outputs every clock. It covers writes that coincide with pixels, pixel bubbles, and back-to-back illegal accesses.

// File: rtl/bpv_pkg.sv
package bpv_pkg;
  localparam int unsigned PLANES_DEF   = 16;
  localparam int unsigned GROUP_W_DEF  = 8;
  localparam int unsigned LANE_W       = 8;
  localparam int unsigned SYNC_DEF     = 2;

  function automatic int unsigned sel_width(input int unsigned groups);
    return (groups > 1) ? $clog2(groups) : 1;
  endfunction
endpackage

// File: rtl/bpv_rst_sync.sv
module bpv_rst_sync #(
  parameter int unsigned STAGES = bpv_pkg::SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/bpv_regport.sv
module bpv_regport #(
  parameter int unsigned WORD_W = bpv_pkg::PLANES_DEF,
  localparam int unsigned BE_W  = WORD_W / bpv_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [BE_W-1:0]   be,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] en_q,
  output logic [WORD_W-1:0] rdata,
  output logic              acc_err
);
  logic              whole;
  logic              wr_ok;
  logic              bad_acc;
  logic [WORD_W-1:0] en_d;
  logic [WORD_W-1:0] rdata_d;

  always_comb begin
    whole   = &be;
    wr_ok   = wr & whole;
    bad_acc = (wr | rd) & ~whole;
    en_d    = wr_ok ? wdata : en_q;
    rdata_d = (rd & whole) ? en_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '1;
      rdata   <= '0;
      acc_err <= 1'b0;
    end else begin
      if (wr_ok) en_q <= en_d;
      rdata   <= rdata_d;
      acc_err <= bad_acc;
    end
  end

  // R3
  partial_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(&be)) |=> $stable(en_q));
  // R4
  partial_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !(&be)) |=> (rdata == '0));
  // R5
  err_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr || rd) && (&be) |=> !acc_err);
  // R2
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/bpv_mask.sv
module bpv_mask #(
  parameter int unsigned PLANES  = bpv_pkg::PLANES_DEF,
  parameter int unsigned GROUP_W = bpv_pkg::GROUP_W_DEF,
  localparam int unsigned GROUPS = PLANES / GROUP_W,
  localparam int unsigned SEL_W  = bpv_pkg::sel_width(GROUPS)
) (
  input  logic [PLANES-1:0]  word,
  input  logic [PLANES-1:0]  en,
  input  logic [SEL_W-1:0]   sel,
  output logic [GROUP_W-1:0] idx
);
  logic [PLANES-1:0]  masked;
  logic [GROUP_W-1:0] grp [GROUPS];

  assign masked = word & en;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign grp[g] = masked[g*GROUP_W +: GROUP_W];
  end

  always_comb begin
    idx = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (sel == SEL_W'(g)) idx = grp[g];
    end
  end
endmodule

// File: rtl/bpv_outreg.sv
module bpv_outreg #(
  parameter int unsigned IDX_W = bpv_pkg::GROUP_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_in,
  input  logic [IDX_W-1:0] idx_in,
  output logic             vld_q,
  output logic [IDX_W-1:0] idx_q
);
  logic             vld_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    vld_d = vld_in;
    idx_d = vld_in ? idx_in : idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (vld_in) idx_q <= idx_d;
    end
  end

  // R9
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_in |=> vld_q);
  // R9
  bubble_holds_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_in |=> (!vld_q && $stable(idx_q)));
endmodule

// File: rtl/bitplane_index_gate.sv
module bitplane_index_gate #(
  parameter int unsigned PLANES  = bpv_pkg::PLANES_DEF,
  parameter int unsigned GROUP_W = bpv_pkg::GROUP_W_DEF,
  localparam int unsigned GROUPS = PLANES / GROUP_W,
  localparam int unsigned SEL_W  = bpv_pkg::sel_width(GROUPS),
  localparam int unsigned BE_W   = PLANES / bpv_pkg::LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [BE_W-1:0]    reg_be,
  input  logic [PLANES-1:0]  reg_wdata,
  output logic [PLANES-1:0]  reg_rdata,
  output logic               reg_acc_err,
  input  logic               pix_valid,
  input  logic [PLANES-1:0]  pix_word,
  input  logic [SEL_W-1:0]   img_sel,
  output logic               lut_valid,
  output logic [GROUP_W-1:0] lut_idx
);
  logic               rst_n_int;
  logic [PLANES-1:0]  plane_en;
  logic [GROUP_W-1:0] idx_comb;

  bpv_rst_sync #(.STAGES(bpv_pkg::SYNC_DEF)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  bpv_regport #(.WORD_W(PLANES)) u_reg (
    .clk(clk), .rst_n(rst_n_int), .wr(reg_wr), .rd(reg_rd), .be(reg_be),
    .wdata(reg_wdata), .en_q(plane_en), .rdata(reg_rdata), .acc_err(reg_acc_err)
  );

  bpv_mask #(.PLANES(PLANES), .GROUP_W(GROUP_W)) u_mask (
    .word(pix_word), .en(plane_en), .sel(img_sel), .idx(idx_comb)
  );

  bpv_outreg #(.IDX_W(GROUP_W)) u_out (
    .clk(clk), .rst_n(rst_n_int), .vld_in(pix_valid), .idx_in(idx_comb),
    .vld_q(lut_valid), .idx_q(lut_idx)
  );

  // R6 R7
  low_group_mask_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (pix_valid && img_sel == '0) |=> ((lut_idx & ~$past(plane_en[GROUP_W-1:0])) == '0));
  // R10
  en_no_glitch_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !(reg_wr && (&reg_be)) |=> $stable(plane_en));
endmodule

// File: tb/bitplane_index_gate_bench.sv
`timescale 1ns/1ps
module bitplane_index_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_be = 2'b11;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_acc_err;
  logic        pix_valid = 1'b0;
  logic [15:0] pix_word = '0;
  logic        img_sel = 1'b0;
  logic        lut_valid;
  logic [7:0]  lut_idx;

  integer errors = 0, checks = 0, cycles = 0;
  bit     cmp_on = 1'b0;
  string  tag = "R1";

  // behavioural model
  integer m_en, e_idx, e_rd;
  bit     e_vld, e_err;

  always #4 clk = ~clk;

  bitplane_index_gate u_bitplane_index_gate (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_acc_err(reg_acc_err),
    .pix_valid(pix_valid), .pix_word(pix_word), .img_sel(img_sel),
    .lut_valid(lut_valid), .lut_idx(lut_idx)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 16'hFFFF; e_idx = 0; e_rd = 0; e_vld = 0; e_err = 0;
    end else begin
      integer masked;
      masked = pix_word & m_en;
      e_vld = pix_valid;
      if (pix_valid) e_idx = img_sel ? ((masked >> 8) & 255) : (masked & 255);
      e_rd  = (reg_rd && reg_be == 2'b11) ? m_en : 0;
      e_err = (reg_rd || reg_wr) && (reg_be != 2'b11);
      if (reg_wr && reg_be == 2'b11) m_en = reg_wdata;
    end
  end

  task automatic check(input string req, input string what, input integer act, input integer exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      check(tag, "lut_valid", lut_valid, e_vld);
      check(tag, "lut_idx", lut_idx, e_idx);
      check(tag, "reg_rdata", reg_rdata, e_rd);
      check(tag, "reg_acc_err", reg_acc_err, e_err);
    end
  end

  task automatic idle();
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; reg_be = 2'b11; pix_valid = 0;
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1; reg_rd = 0; reg_be = be; reg_wdata = d; pix_valid = 0;
  endtask

  task automatic rd(input logic [1:0] be);
    @(negedge clk);
    reg_wr = 0; reg_rd = 1; reg_be = be; pix_valid = 0;
  endtask

  task automatic pix(input logic [15:0] w, input logic s);
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; reg_be = 2'b11;
    pix_valid = 1; pix_word = w; img_sel = s;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", "lut_valid in reset", lut_valid, 0);
    check("R1", "reg_acc_err in reset", reg_acc_err, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1'b1;
    check("R1", "lut_idx after reset", lut_idx, 0);
    check("R1", "reg_rdata after reset", reg_rdata, 0);
    tag = "R1";
    rd(2'b11); idle();
    @(negedge clk);
    tag = "R7"; pix(16'hA55A, 0); pix(16'h1234, 0); pix(16'hFFFF, 0);
    tag = "R8"; pix(16'hA55A, 1); pix(16'h8001, 1); pix(16'h00FF, 1);
    tag = "R2"; wr(2'b11, 16'h0F3C); rd(2'b11); idle(); rd(2'b11); idle();
    tag = "R6";
    for (int i = 0; i < 16; i++) pix(16'h1 << i, i >= 8);
    pix(16'hFFFF, 0); pix(16'hFFFF, 1);
    tag = "R3"; wr(2'b01, 16'h0000); wr(2'b10, 16'h0000); wr(2'b00, 16'h0000);
    rd(2'b11); idle();
    tag = "R5"; rd(2'b01); idle(); wr(2'b10, 16'h1111); wr(2'b11, 16'hF0F0); idle();
    tag = "R4"; rd(2'b10); rd(2'b00); rd(2'b11); idle();
    tag = "R10";
    pix(16'hFFFF, 0);
    @(negedge clk);
    reg_wr = 1; reg_be = 2'b11; reg_wdata = 16'h00AA; pix_valid = 1; pix_word = 16'hFFFF; img_sel = 0;
    pix(16'hFFFF, 0); pix(16'hFFFF, 1);
    tag = "R9";
    pix(16'h5A5A, 0); idle(); idle(); pix(16'h00FF, 0); idle(); pix(16'hFFFF, 1); idle();
    wr(2'b11, 16'hFFFF);
    for (int i = 0; i < 20; i++) pix(16'((i * 40503) ^ 16'h3C96), i[0]);
    idle(); idle();
    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule